// File: doc/BRIEF.md
# Programmable GPIO Bank with Pin Interrupts

This block is a bank of general-purpose pins, `N` wide, behind a small memory-mapped write/read port. Software sets each pin's direction and output value, reads the pin levels, and arms an interrupt per pin. The output register can be changed with plain writes. It can also be changed through clear, set and toggle aliases, which modify only the selected bits in one bus cycle, so software never has to read the register first.

Pin inputs cross into the clock domain through a two-flop synchronizer. Each pin can be set to detect an edge or a level, with its own polarity and its own mask. A detected condition sets a sticky status bit. Software clears a status bit by writing a one to it. The OR of all status bits drives one request line. The block has an active-low asynchronous reset.

Top module: `gpio_bank`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zeros, `irq` is 0, the mask register reads all ones, the polarity register reads all ones, and the status register reads zero.
- R2: The register is selected by `bus_addr[6:3]`. The codes are: 0 direction, 1 pin input, 2 output, 3 output clear, 4 output set, 5 output toggle, 6 mask, 7 type, 8 polarity, 9 status, 10 status clear. Address bits [2:0] have no effect on the selection. Writes to codes 11 to 15 change nothing, and reads of those codes return 0.
- R3: A write to code 0 sets `pin_oe` on the next cycle, with bit value 1 meaning the pin is an output.
- R4: A write to code 2 replaces the whole output register, which drives `pin_out` on the next cycle.
- R5: A write to code 3 makes the output `out & ~data`. A write to code 4 makes it `out | data`. A write to code 5 makes it `out ^ data`.
- R6: A read of code 1 returns `pin_in` after it has passed through two flops. A level held for three cycles is therefore read back as that level.
- R7: For a pin of edge type (type bit 0), a rising edge latches the status bit when the polarity bit is 1, and a falling edge latches it when the polarity bit is 0. The bit latches on the third clock edge after the pin changes. An edge of the other direction latches nothing.
- R8: For a pin of level type (type bit 1), the status bit latches while the pin is at its active level: high when the polarity bit is 1, low when it is 0.
- R9: A pin whose mask bit is 1 never sets its status bit.
- R10: Writing ones to code 10 clears the matching status bits. If a new condition occurs on the same bit in the same cycle, the bit stays set, so a level that is still active keeps its bit set.
- R11: `irq` is high exactly when at least one status bit is set.
- R12: A read strobe on `bus_re` gives `bus_rvalid` high with `bus_rdata` on the next cycle. Reads of codes 3, 4, 5 and 10 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address; bits [6:3] select the register |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| pin_in | input | N | Pin levels from the pads |
| pin_out | output | N | Output values to the pads |
| pin_oe | output | N | Output enables to the pads |
| irq | output | 1 | OR of all latched interrupt bits |

## Verification
The assertions assume that `bus_we` and `bus_re` are low while reset is asserted and in the first cycle after it. They also assume that a write and a read are never issued in the same cycle. The bench holds both strobes low through reset and drives only one operation per task call. The bench changes `pin_in` only at falling edges, and only while every unmasked pin is in a known configuration, so each expected latch can be predicted cycle by cycle.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int N  = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  output logic          bus_rvalid,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          irq
);

  localparam logic [3:0] C_DIR  = 4'h0;
  localparam logic [3:0] C_IN   = 4'h1;
  localparam logic [3:0] C_OUT  = 4'h2;
  localparam logic [3:0] C_CLR  = 4'h3;
  localparam logic [3:0] C_SET  = 4'h4;
  localparam logic [3:0] C_TGL  = 4'h5;
  localparam logic [3:0] C_MASK = 4'h6;
  localparam logic [3:0] C_TYPE = 4'h7;
  localparam logic [3:0] C_POL  = 4'h8;
  localparam logic [3:0] C_STAT = 4'h9;
  localparam logic [3:0] C_ACK  = 4'hA;
  localparam logic [N-1:0] ONES = {N{1'b1}};

  logic [3:0]   code;
  logic [N-1:0] dir_q, out_q, mask_q, type_q, pol_q, stat_q;
  logic [N-1:0] sync1_q, sync2_q, prev_q;
  logic [N-1:0] rise, fall, hit, ack;

  assign code = bus_addr[6:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= ONES;
      type_q <= '0;
      pol_q  <= ONES;
    end else if (bus_we) begin
      case (code)
        C_DIR:  dir_q  <= bus_wdata;
        C_OUT:  out_q  <= bus_wdata;
        C_CLR:  out_q  <= out_q & ~bus_wdata;
        C_SET:  out_q  <= out_q | bus_wdata;
        C_TGL:  out_q  <= out_q ^ bus_wdata;
        C_MASK: mask_q <= bus_wdata;
        C_TYPE: type_q <= bus_wdata;
        C_POL:  pol_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;

  for (genvar i = 0; i < N; i++) begin : g_det
    always_comb begin
      if (type_q[i]) hit[i] = pol_q[i] ? sync2_q[i] : ~sync2_q[i];
      else           hit[i] = pol_q[i] ? rise[i] : fall[i];
      hit[i] = hit[i] & ~mask_q[i];
    end
  end

  assign ack = (bus_we && code == C_ACK) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~ack) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) begin
        case (code)
          C_DIR:  bus_rdata <= dir_q;
          C_IN:   bus_rdata <= sync2_q;
          C_OUT:  bus_rdata <= out_q;
          C_MASK: bus_rdata <= mask_q;
          C_TYPE: bus_rdata <= type_q;
          C_POL:  bus_rdata <= pol_q;
          C_STAT: bus_rdata <= stat_q;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |stat_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N  = 16,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic          bus_re,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic          bus_rvalid,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_oe,
  input logic          irq,
  input logic [N-1:0]  mask_q
);

  logic [3:0] code;
  assign code = bus_addr[6:3];

  a_r3_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && code == 4'h0) |=> pin_oe == $past(bus_wdata));

  a_r4_out_replaced: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && code == 4'h2) |=> pin_out == $past(bus_wdata));

  a_r5_clear_op: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && code == 4'h3) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  a_r5_set_op: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && code == 4'h4) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

  a_r5_toggle_op: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && code == 4'h5) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

  a_r2_out_holds_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (code == 4'h2 || code == 4'h3 || code == 4'h4 || code == 4'h5)) |=> $stable(pin_out));

  a_r9_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mask_q) != {N{1'b1}});

  a_r12_rvalid_follows_re: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);

  a_r12_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !bus_rvalid);

endmodule

bind gpio_bank gpio_bank_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .mask_q(mask_q)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int N = 16;
  localparam int AW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic bus_rvalid, irq;

  int total = 0, bad = 0;
  logic [N-1:0] m_out = '0, m_dir = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.N(N), .AW(AW)) u_dut (.*);

  function automatic logic [N-1:0] model_op(input int c, input logic [N-1:0] o, input logic [N-1:0] d);
    case (c)
      2: return d;
      3: return o & ~d;
      4: return o | d;
      5: return o ^ d;
      default: return o;
    endcase
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int c, input logic [N-1:0] d, input logic [2:0] lo = 3'b000);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'((c << 3) | lo); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int c, output logic [N-1:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = AW'(c << 3);
    @(negedge clk);
    bus_re = 1'b0;
    total++;
    if (bus_rvalid !== 1'b1) begin bad++; $display("FAIL R12 rvalid actual=%b expected=1", bus_rvalid); end
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [N-1:0] r, v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 oe", pin_oe, '0);
    chk("R1 out", pin_out, '0);
    chk("R1 irq", {{(N-1){1'b0}}, irq}, '0);
    rd(6, r); chk("R1 mask", r, '1);
    rd(8, r); chk("R1 pol", r, '1);
    rd(9, r); chk("R1 status", r, '0);

    for (int k = 0; k < 20; k++) begin
      v = N'($urandom);
      @(negedge clk); pin_in = v;
      settle(3);
      rd(1, r); chk("R6 pin read", r, v);
    end
    rd(9, r); chk("R9 masked pins never latch", r, '0);

    for (int k = 0; k < 200; k++) begin
      int c;
      c = int'($urandom_range(0, 5));
      if (c == 1) c = 0;
      v = N'($urandom);
      wr(c, v, 3'($urandom));
      if (c == 0) m_dir = v; else m_out = model_op(c, m_out, v);
      if (c == 0) chk("R3 dir to oe", pin_oe, m_dir);
      else if (c == 2) chk("R4 out write", pin_out, m_out);
      else chk("R5 atomic op", pin_out, m_out);
    end
    rd(2, r); chk("R2 out readback", r, m_out);
    rd(4, r); chk("R12 alias reads zero", r, '0);
    wr(11, '1); wr(15, '1);
    chk("R2 unmapped write ignored", pin_out, m_out);
    rd(0, r); chk("R2 dir unchanged", r, m_dir);
    rd(13, r); chk("R2 unmapped read zero", r, '0);

    @(negedge clk); pin_in = '0;
    settle(4);
    wr(7, 16'h0004);
    wr(8, 16'hFFFD);
    wr(6, 16'hFFF0);
    settle(2);
    rd(9, r); chk("R7 quiet start", r, '0);

    @(negedge clk); pin_in[0] = 1'b1;
    settle(2);
    chk("R11 not yet", {{(N-1){1'b0}}, irq}, '0);
    settle(1);
    chk("R11 irq high", {{(N-1){1'b0}}, irq}, 1);
    rd(9, r); chk("R7 rising latched", r, 16'h0001);
    wr(10, 16'h0001);
    chk("R10 cleared irq", {{(N-1){1'b0}}, irq}, '0);

    @(negedge clk); pin_in[1] = 1'b1;
    settle(4);
    rd(9, r); chk("R7 wrong edge ignored", r, '0);
    @(negedge clk); pin_in[1] = 1'b0;
    settle(4);
    rd(9, r); chk("R7 falling latched", r, 16'h0002);
    wr(10, 16'h0002);

    @(negedge clk); pin_in[2] = 1'b1;
    settle(4);
    rd(9, r); chk("R8 level latched", r, 16'h0004);
    wr(10, 16'h0004);
    rd(9, r); chk("R10 set wins while active", r, 16'h0004);
    @(negedge clk); pin_in[2] = 1'b0;
    settle(4);
    wr(10, 16'h0004);
    rd(9, r); chk("R10 clear sticks after level drops", r, '0);

    wr(8, 16'hFFF9);
    settle(1);
    rd(9, r); chk("R8 active-low level", r, 16'h0004);
    wr(8, 16'hFFFD);
    wr(10, 16'hFFFF);

    @(negedge clk); pin_in[3] = 1'b1;
    settle(4);
    @(negedge clk); pin_in[8] = 1'b1;
    settle(4);
    rd(9, r); chk("R9 mask blocks", r, 16'h0008);
    chk("R11 irq from one bit", {{(N-1){1'b0}}, irq}, 1);
    wr(10, 16'h0008);
    chk("R11 irq low", {{(N-1){1'b0}}, irq}, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule